// File: doc/BRIEF.md
# Multi-Word Code Memory Loader

This block builds one wide operand out of a read-only program memory that holds 16-bit words, with the first word at index 0. A start strobe gives a word address and a word count. The loader reads that many consecutive words through a synchronous read port and shifts each word into an accumulator. The word at the start address becomes the most significant word, and each later word moves toward the least significant end. When the last word has arrived, the loader copies the accumulator to the result output and pulses done for one cycle. Constants written directly in a program are limited to 16 bits, so a wider constant has to be fetched this way.

A single-word mode fetches exactly one word and ignores the count. The range is checked against the program length when the request is accepted. A count larger than the result can hold, or any word address at or beyond the program length, raises an error together with done. In that case the result is not written and the memory is not read. A count of zero completes at once with a zero result. The loader ignores a start that arrives while a load is in progress.

Top module: `mw_code_loader`

## Requirements
- R1: While reset is active (`rst_n` low), `done_o`, `err_o` and `mem_rd_o` are low and `result_o` is zero.
- R2: A multi-word load of N words from address A gives `result_o` = {word[A], word[A+1], ..., word[A+N-1]}, zero-extended on the left. word[A] is the most significant of these words, and the last word occupies bits 15:0.
- R3: When `single_i` is 1, exactly one word is loaded and `count_i` is ignored. The result is that word in bits 15:0, with zeros above.
- R4: The loader asserts `mem_rd_o` for N consecutive cycles with ascending addresses A..A+N-1. It expects read data one cycle after each request. Counting the clock edge that samples `start_i` as edge 0, `done_o` is visible after edge N+1.
- R5: A count above RW/16 raises `err_o` with `done_o` in the cycle after the start edge. No memory read takes place and `result_o` keeps its previous value.
- R6: If A+N exceeds `prog_len_i` for a nonzero N, the request fails: `err_o` and `done_o` rise in the cycle after the start edge, no read is issued, and `result_o` is unchanged. Every issued read address is below `prog_len_i`.
- R7: A count of zero in multi-word mode sets `result_o` to zero and raises `done_o` in the cycle after the start edge. It raises no error and issues no read, whatever the address.
- R8: A start that arrives while a load is in progress is ignored. It does not alter the load's result and produces no second done.
- R9: `done_o` and `err_o` each stay high for one cycle per request. `err_o` is never high without `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| single_i | input | 1 | 1: load one word and ignore the count |
| addr_i | input | AW | First word address |
| count_i | input | CW | Number of words in multi-word mode |
| prog_len_i | input | AW+1 | Program length in words; held stable during a load |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address |
| mem_data_i | input | 16 | Read data, valid the cycle after the request |
| result_o | output | RW | Assembled value |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle error pulse, coincident with done |

## Verification
The hardest case to reach is a start that arrives partway through a multi-word load. Reads are in flight at that moment and the accumulator is half full. The bench starts a four-word load, raises a second start two cycles later with a different address and count, and then checks three things: the first load's value arrives, exactly one done appears, and no further done follows. Boundary loads use the last legal word, the full capacity of the result, and a request that runs one word past the program end. These show that range checking acts on the whole span, not only on the start address.

// File: rtl/mw_code_loader.sv
module mw_code_loader #(
  parameter int AW = 12,
  parameter int CW = 5,
  parameter int RW = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          single_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW:0]   prog_len_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [15:0]   mem_data_i,
  output logic [RW-1:0] result_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int MAXW = RW / 16;
  localparam int EW = ((AW > CW) ? AW : CW) + 2;

  logic          busy, rd_q;
  logic [CW-1:0] issue_left, recv_left;
  logic [RW-1:0] acc;

  logic [CW-1:0] eff_cnt;
  logic [EW-1:0] cnt_x, end_x;
  logic          too_big, out_rng, bad, accept;

  assign eff_cnt = single_i ? CW'(1) : count_i;
  assign cnt_x   = EW'(eff_cnt);
  assign end_x   = EW'(addr_i) + cnt_x;
  assign too_big = cnt_x > EW'(MAXW);
  assign out_rng = (eff_cnt != '0) && (end_x > EW'(prog_len_i));
  assign bad     = too_big || out_rng;
  assign accept  = start_i && !busy;

  logic [RW-1:0] acc_next;
  assign acc_next = {acc[RW-17:0], mem_data_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      rd_q       <= 1'b0;
      mem_rd_o   <= 1'b0;
      mem_addr_o <= '0;
      issue_left <= '0;
      recv_left  <= '0;
      acc        <= '0;
      result_o   <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      rd_q   <= mem_rd_o;
      if (accept) begin
        if (bad) begin
          done_o <= 1'b1;
          err_o  <= 1'b1;
        end else if (eff_cnt == '0) begin
          done_o   <= 1'b1;
          result_o <= '0;
        end else begin
          busy       <= 1'b1;
          mem_rd_o   <= 1'b1;
          mem_addr_o <= addr_i;
          issue_left <= eff_cnt - CW'(1);
          recv_left  <= eff_cnt;
          acc        <= '0;
        end
      end else if (busy) begin
        if (mem_rd_o) begin
          if (issue_left != '0) begin
            mem_addr_o <= mem_addr_o + AW'(1);
            issue_left <= issue_left - CW'(1);
          end else begin
            mem_rd_o <= 1'b0;
          end
        end
        if (rd_q) begin
          acc       <= acc_next;
          recv_left <= recv_left - CW'(1);
          if (recv_left == CW'(1)) begin
            result_o <= acc_next;
            done_o   <= 1'b1;
            busy     <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mw_code_loader_chk.sv
module mw_code_loader_chk #(
  parameter int AW = 12,
  parameter int RW = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          mem_rd_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [AW:0]   prog_len_i,
  input logic [RW-1:0] result_o,
  input logic          done_o,
  input logic          err_o
);
  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  assert_read_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> ({1'b0, mem_addr_o} < prog_len_i));

  assert_no_write_on_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $stable(result_o));

  assert_read_follows_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_o) |-> $past(start_i));

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (!done_o && !err_o && !mem_rd_o));
endmodule

bind mw_code_loader mw_code_loader_chk #(.AW(AW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .mem_rd_o(mem_rd_o),
  .mem_addr_o(mem_addr_o), .prog_len_i(prog_len_i), .result_o(result_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/test_mw_code_loader.sv
module test_mw_code_loader;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12, CW = 5, RW = 256;
  localparam int PLEN = 1000;

  logic clk = 0, rst_n = 0, start = 0, single = 0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] cnt = '0;
  logic [AW:0] plen = (AW+1)'(PLEN);
  logic mem_rd, done, err;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_q;
  logic [RW-1:0] result;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_code_loader #(.AW(AW), .CW(CW), .RW(RW)) i_mw_code_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .single_i(single),
    .addr_i(addr), .count_i(cnt), .prog_len_i(plen),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_q),
    .result_o(result), .done_o(done), .err_o(err));

  function automatic logic [15:0] memf(input logic [AW-1:0] a);
    logic [31:0] v;
    v = {20'd0, a} * 32'd40503 + 32'd7;
    return v[15:0] ^ {4'd0, a};
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_q <= memf(mem_addr);

  function automatic logic [RW-1:0] expect_val(input logic [AW-1:0] a, input int n);
    logic [RW-1:0] v = '0;
    for (int k = 0; k < n; k++) v = {v[RW-17:0], memf(a + AW'(k))};
    return v;
  endfunction

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic s, input logic [AW-1:0] a, input logic [CW-1:0] c,
                         output int lat);
    @(negedge clk);
    single = s; addr = a; cnt = c; start = 1;
    @(posedge clk); #1 start = 0;
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk); #1 lat++;
    end
  endtask

  // fields: single, addr, count, expect error
  localparam logic [18:0] VEC [12] = '{
    {1'b0, 12'd0,    5'd1,  1'b0},
    {1'b0, 12'd5,    5'd3,  1'b0},
    {1'b0, 12'd100,  5'd16, 1'b0},
    {1'b0, 12'd984,  5'd16, 1'b0},
    {1'b0, 12'd985,  5'd16, 1'b1},
    {1'b0, 12'd999,  5'd1,  1'b0},
    {1'b0, 12'd1000, 5'd1,  1'b1},
    {1'b0, 12'd10,   5'd17, 1'b1},
    {1'b0, 12'd20,   5'd0,  1'b0},
    {1'b0, 12'd4000, 5'd0,  1'b0},
    {1'b1, 12'd30,   5'd9,  1'b0},
    {1'b1, 12'd1000, 5'd0,  1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] last;
    int lat;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset done", RW'(done), '0);
    check("R1 reset err", RW'(err), '0);
    check("R1 reset rd", RW'(mem_rd), '0);
    check("R1 reset result", result, '0);
    @(negedge clk) rst_n = 1;

    last = '0;
    foreach (VEC[i]) begin
      logic s, e;
      logic [AW-1:0] a;
      logic [CW-1:0] c;
      int n;
      {s, a, c, e} = VEC[i];
      n = s ? 1 : int'(c);
      do_load(s, a, c, lat);
      if (!e) last = (n == 0) ? '0 : expect_val(a, n);
      if (s) check("R3 single word", result, last);
      else if (e && c > 5'd16) check("R5 oversize no write", result, last);
      else if (e) check("R6 range no write", result, last);
      else if (n == 0) check("R7 zero count", result, last);
      else check("R2 assembled value", result, last);
      check("R9 done/err", {done, err}, {1'b1, e});
      check("R4 latency", RW'(lat), (e || n == 0) ? '0 : RW'(n + 1));
      @(posedge clk); #1;
      check("R9 done one cycle", RW'(done), '0);
    end

    // R8: second start during a load is ignored
    begin
      int seen = 0;
      @(negedge clk);
      single = 0; addr = 12'd200; cnt = 5'd4; start = 1;
      @(negedge clk); start = 0;
      @(negedge clk);
      addr = 12'd600; cnt = 5'd2; start = 1;
      @(negedge clk); start = 0;
      for (int k = 0; k < 20; k++) begin
        @(posedge clk); #1;
        if (done) begin
          seen++;
          check("R8 first load kept", result, expect_val(12'd200, 4));
        end
      end
      check("R8 single done", RW'(seen), RW'(1));
    end

    // R4: back-to-back read addresses
    begin
      int bad_order = 0;
      logic [AW-1:0] expa = 12'd50;
      @(negedge clk);
      single = 0; addr = 12'd50; cnt = 5'd5; start = 1;
      @(negedge clk); start = 0;
      for (int k = 0; k < 10; k++) begin
        #1;
        if (mem_rd) begin
          if (mem_addr !== expa) bad_order++;
          expa = expa + 1;
        end
        @(negedge clk);
      end
      check("R4 read sequence", RW'(bad_order), '0);
      check("R4 read count", RW'(expa), RW'(55));
      check("R2 after sequence", result, expect_val(12'd50, 5));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule